// File: doc/BRIEF.md
# Coprocessor Host Register Window

This block is the byte-wide register window that a host processor uses to configure and launch a graphics coprocessor. Behind it sit sixteen 16-bit general registers, a 16-bit status word, and a set of 8-bit control registers. The control registers cover program, ROM and RAM bank selection, backup RAM enable, multiplier speed and interrupt mask, screen base, clock rate and screen mode. A 16-bit cache base register and a read-only version byte complete the set. The host reaches everything through one select and one write strobe, an address, and byte-wide data in each direction. Read data is registered and appears on the cycle after the request.

Some accesses have side effects. Writing the high byte of the last general register, which serves as the program counter, sets the running flag. The core's stop pulse clears it again. A host read of the status word's high byte returns the interrupt flag and then clears it. On the core side there are pulses to raise an interrupt and to stop, plus a strobe that loads the arithmetic and mode flags. The block drives a registered interrupt output gated by the mask bit, and it exports the decoded screen-mode, grant and bank fields.

Top module: `gfx_host_regs`

## Requirements
- R1: General register n occupies byte offsets 2n (low byte) and 2n+1 (high byte), for n = 0..15. Each byte write changes only that byte. A host read returns the addressed byte on `host_rdata` in the cycle after the request.
- R2: The status word is read at offset 0x030 (bits 7:0) and 0x031 (bits 15:8). Only bits 1..6, 8..12 and 15 exist, and every other bit reads 0. A host write to either byte loads the existing bits of that byte, except bit 15. The word resets to 0.
- R3: A host write to offset 0x01F sets status bit 5 and `run` on the next edge. A write to 0x01E alone does not.
- R4: A `core_stop` pulse clears status bit 5 and `run`. If it coincides with a write to 0x01F, the start wins.
- R5: A `core_irq` pulse sets status bit 15. A host read of 0x031 returns the byte as it was before the read, then clears bit 15. If `core_irq` coincides with that read, bit 15 stays set.
- R6: `irq_out` is a register loaded each cycle with status bit 15 AND NOT configuration bit 7, so it lags the flag by one cycle.
- R7: The cache base register sits at 0x03E (low byte) and 0x03F (high byte). Bits 3..0 always read 0.
- R8: Offset 0x03B reads the parameter VERSION (default 0x04), and host writes to it have no effect.
- R9: The screen mode register at 0x03A drives outputs as follows: `depth_code` = {bit1, bit0}, `height_code` = {bit5, bit2}, `rom_grant` = bit4 and `ram_grant` = bit3. It reads back bits 5..0 only.
- R10: The configuration register at 0x037 keeps bits 7 (interrupt mask) and 5 (`fast_mult`). The clock register at 0x039 keeps bit 0 (`clk_double`). The backup RAM register at 0x033 keeps bit 0. All other bits of these registers read 0.
- R11: Offsets with no register (0x020..0x02F, 0x032, 0x035, 0x03D, 0x040 and above) read 0, and writes there change no register.
- R12: While `core_flags_we` is high, status bits 1..4, 6 and 8..12 load from the same bits of `core_flags`. Bits 5 and 15 are untouched.
- R13: The bank registers at 0x034 (program), 0x036 (ROM) and 0x03C (RAM), and the screen base at 0x038, hold all 8 bits. Each drives its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access request this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset within the window |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after a read |
| core_flags_we | input | 1 | Load core-owned status flags |
| core_flags | input | 16 | New flag values, in status bit positions |
| core_irq | input | 1 | Core interrupt request pulse |
| core_stop | input | 1 | Core stop pulse, clears running flag |
| run | output | 1 | Core running flag |
| irq_out | output | 1 | Masked, registered interrupt to the host |
| depth_code | output | 2 | Colour depth code |
| height_code | output | 2 | Screen height code |
| rom_grant | output | 1 | ROM owned by the core |
| ram_grant | output | 1 | RAM owned by the core |
| fast_mult | output | 1 | High-speed multiply select |
| clk_double | output | 1 | Double clock rate select |
| backup_ram_en | output | 1 | Backup RAM enable |
| prog_bank | output | 8 | Program bank |
| rom_bank | output | 8 | ROM data bank |
| ram_bank | output | 8 | RAM bank |
| screen_base | output | 8 | Screen base |
| cache_base | output | 16 | Cache base, low nibble zero |

## Verification
The assertions assume a well-formed host bus: `host_we` and `host_addr` have meaning only while `host_sel` is high, and each access lasts exactly one cycle. They also assume `core_irq` and `core_stop` arrive as pulses between reset and the checks that rely on them. The stimulus drives every access as a single-cycle strobe that starts and ends on falling edges. It issues the coincident cases, start with stop and interrupt with clearing read, as deliberate single cycles, so that each priority rule is observed exactly once without overlapping traffic.

// File: rtl/gfxw_pkg.sv
package gfxw_pkg;
  // status bit positions
  localparam int SFR_RUN = 5;
  localparam int SFR_IRQ = 15;
  // existing status bits, those the host may load, those the core may load
  localparam logic [15:0] SFR_EXIST = 16'h9F7E;
  localparam logic [15:0] SFR_HOST  = 16'h1F7E;
  localparam logic [15:0] SFR_CORE  = 16'h1F5E;
  // byte offsets of the non-general registers
  localparam int OFS_SFR_LO = 'h030;
  localparam int OFS_SFR_HI = 'h031;
  localparam int OFS_BRAM   = 'h033;
  localparam int OFS_PBANK  = 'h034;
  localparam int OFS_RBANK  = 'h036;
  localparam int OFS_CFG    = 'h037;
  localparam int OFS_SBASE  = 'h038;
  localparam int OFS_CLK    = 'h039;
  localparam int OFS_SMODE  = 'h03A;
  localparam int OFS_VER    = 'h03B;
  localparam int OFS_WBANK  = 'h03C;
  localparam int OFS_CB_LO  = 'h03E;
  localparam int OFS_CB_HI  = 'h03F;
  // keep masks of the narrow registers
  localparam logic [7:0] CFG_KEEP   = 8'hA0;
  localparam logic [7:0] SMODE_KEEP = 8'h3F;
  localparam logic [7:0] BIT0_KEEP  = 8'h01;
  localparam logic [7:0] CBLO_KEEP  = 8'hF0;
endpackage

// File: rtl/gfxw_gpr_file.sv
module gfxw_gpr_file #(
  parameter int NUM_REGS = 16,
  localparam int BYTES = 2 * NUM_REGS,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata_q
);
  logic [7:0] mem [BYTES];

  // single-port byte store, registered read, no reset: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    rdata_q <= mem[idx];
  end
endmodule

// File: rtl/gfxw_status.sv
module gfxw_status
  import gfxw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        host_we_lo,
  input  logic        host_we_hi,
  input  logic [7:0]  wdata,
  input  logic        start,
  input  logic        rd_clr,
  input  logic        core_flags_we,
  input  logic [15:0] core_flags,
  input  logic        core_irq,
  input  logic        core_stop,
  output logic [15:0] sfr_q
);
  logic [15:0] nxt;

  always_comb begin
    nxt = sfr_q;
    if (host_we_lo) nxt[7:0]  = (nxt[7:0]  & ~SFR_HOST[7:0])  | (wdata & SFR_HOST[7:0]);
    if (host_we_hi) nxt[15:8] = (nxt[15:8] & ~SFR_HOST[15:8]) | (wdata & SFR_HOST[15:8]);
    if (core_flags_we) nxt = (nxt & ~SFR_CORE) | (core_flags & SFR_CORE);
    if (rd_clr)    nxt[SFR_IRQ] = 1'b0;
    if (core_irq)  nxt[SFR_IRQ] = 1'b1;
    if (core_stop) nxt[SFR_RUN] = 1'b0;
    if (start)     nxt[SFR_RUN] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sfr_q <= '0;
    else     sfr_q <= nxt & SFR_EXIST;
  end
endmodule

// File: rtl/gfxw_ctrl.sv
module gfxw_ctrl
  import gfxw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [7:0] VERSION = 8'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        bram_q,
  output logic [7:0]        pbank_q,
  output logic [7:0]        rbank_q,
  output logic [7:0]        cfg_q,
  output logic [7:0]        sbase_q,
  output logic [7:0]        clk_q,
  output logic [7:0]        smode_q,
  output logic [7:0]        wbank_q,
  output logic [15:0]       cbase_q,
  output logic [7:0]        rd_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bram_q <= '0; pbank_q <= '0; rbank_q <= '0; cfg_q <= '0;
      sbase_q <= '0; clk_q <= '0; smode_q <= '0; wbank_q <= '0;
      cbase_q <= '0;
    end else if (we) begin
      case (addr)
        ADDR_W'(OFS_BRAM):  bram_q  <= wdata & BIT0_KEEP;
        ADDR_W'(OFS_PBANK): pbank_q <= wdata;
        ADDR_W'(OFS_RBANK): rbank_q <= wdata;
        ADDR_W'(OFS_CFG):   cfg_q   <= wdata & CFG_KEEP;
        ADDR_W'(OFS_SBASE): sbase_q <= wdata;
        ADDR_W'(OFS_CLK):   clk_q   <= wdata & BIT0_KEEP;
        ADDR_W'(OFS_SMODE): smode_q <= wdata & SMODE_KEEP;
        ADDR_W'(OFS_WBANK): wbank_q <= wdata;
        ADDR_W'(OFS_CB_LO): cbase_q[7:0]  <= wdata & CBLO_KEEP;
        ADDR_W'(OFS_CB_HI): cbase_q[15:8] <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(OFS_BRAM):  rd_val = bram_q;
      ADDR_W'(OFS_PBANK): rd_val = pbank_q;
      ADDR_W'(OFS_RBANK): rd_val = rbank_q;
      ADDR_W'(OFS_CFG):   rd_val = cfg_q;
      ADDR_W'(OFS_SBASE): rd_val = sbase_q;
      ADDR_W'(OFS_CLK):   rd_val = clk_q;
      ADDR_W'(OFS_SMODE): rd_val = smode_q;
      ADDR_W'(OFS_VER):   rd_val = VERSION;
      ADDR_W'(OFS_WBANK): rd_val = wbank_q;
      ADDR_W'(OFS_CB_LO): rd_val = cbase_q[7:0];
      ADDR_W'(OFS_CB_HI): rd_val = cbase_q[15:8];
      default:            rd_val = 8'h00;
    endcase
  end
endmodule

// File: rtl/gfx_host_regs.sv
module gfx_host_regs
  import gfxw_pkg::*;
#(
  parameter int NUM_GPR = 16,
  parameter int ADDR_W = 10,
  parameter logic [7:0] VERSION = 8'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              core_flags_we,
  input  logic [15:0]       core_flags,
  input  logic              core_irq,
  input  logic              core_stop,
  output logic              run,
  output logic              irq_out,
  output logic [1:0]        depth_code,
  output logic [1:0]        height_code,
  output logic              rom_grant,
  output logic              ram_grant,
  output logic              fast_mult,
  output logic              clk_double,
  output logic              backup_ram_en,
  output logic [7:0]        prog_bank,
  output logic [7:0]        rom_bank,
  output logic [7:0]        ram_bank,
  output logic [7:0]        screen_base,
  output logic [15:0]       cache_base
);
  localparam int GPR_BYTES = 2 * NUM_GPR;
  localparam int GIDX_W = $clog2(GPR_BYTES);
  localparam logic [ADDR_W-1:0] PC_HI = ADDR_W'(GPR_BYTES - 1);

  logic wr, rd, gpr_hit, start;
  logic [7:0] gpr_rd, ctrl_rd, reg_rd, reg_rd_q;
  logic gpr_sel_q, irq_q;
  logic [15:0] sfr;
  logic [7:0] bram_q, pbank_q, rbank_q, cfg_q, sbase_q, clk_q, smode_q, wbank_q;
  logic cfg_mask;

  assign wr      = host_sel & host_we;
  assign rd      = host_sel & ~host_we;
  assign gpr_hit = host_addr < ADDR_W'(GPR_BYTES);
  assign start   = wr && (host_addr == PC_HI);

  gfxw_gpr_file #(.NUM_REGS(NUM_GPR)) u_gpr (
    .clk(clk), .we(wr & gpr_hit), .idx(host_addr[GIDX_W-1:0]),
    .wdata(host_wdata), .rdata_q(gpr_rd)
  );

  gfxw_status u_sfr (
    .clk(clk), .rst(rst),
    .host_we_lo(wr && host_addr == ADDR_W'(OFS_SFR_LO)),
    .host_we_hi(wr && host_addr == ADDR_W'(OFS_SFR_HI)),
    .wdata(host_wdata), .start(start),
    .rd_clr(rd && host_addr == ADDR_W'(OFS_SFR_HI)),
    .core_flags_we(core_flags_we), .core_flags(core_flags),
    .core_irq(core_irq), .core_stop(core_stop), .sfr_q(sfr)
  );

  gfxw_ctrl #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_ctrl (
    .clk(clk), .rst(rst), .we(wr), .addr(host_addr), .wdata(host_wdata),
    .bram_q(bram_q), .pbank_q(pbank_q), .rbank_q(rbank_q), .cfg_q(cfg_q),
    .sbase_q(sbase_q), .clk_q(clk_q), .smode_q(smode_q), .wbank_q(wbank_q),
    .cbase_q(cache_base), .rd_val(ctrl_rd)
  );

  always_comb begin
    if (host_addr == ADDR_W'(OFS_SFR_LO))      reg_rd = sfr[7:0];
    else if (host_addr == ADDR_W'(OFS_SFR_HI)) reg_rd = sfr[15:8];
    else                                       reg_rd = ctrl_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q  <= '0;
      gpr_sel_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (rd) begin
        reg_rd_q  <= reg_rd;
        gpr_sel_q <= gpr_hit;
      end
      irq_q <= sfr[SFR_IRQ] & ~cfg_q[7];
    end
  end

  assign cfg_mask      = cfg_q[7];
  assign host_rdata    = gpr_sel_q ? gpr_rd : reg_rd_q;
  assign run           = sfr[SFR_RUN];
  assign irq_out       = irq_q;
  assign depth_code    = smode_q[1:0];
  assign height_code   = {smode_q[5], smode_q[2]};
  assign rom_grant     = smode_q[4];
  assign ram_grant     = smode_q[3];
  assign fast_mult     = cfg_q[5];
  assign clk_double    = clk_q[0];
  assign backup_ram_en = bram_q[0];
  assign prog_bank     = pbank_q;
  assign rom_bank      = rbank_q;
  assign ram_bank      = wbank_q;
  assign screen_base   = sbase_q;
endmodule

// File: rtl/gfxw_checker.sv
module gfxw_checker #(
  parameter int ADDR_W = 10,
  parameter logic [7:0] VERSION = 8'h04,
  parameter logic [ADDR_W-1:0] PC_HI = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              host_sel,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_rdata,
  input logic              core_irq,
  input logic              core_stop,
  input logic              run,
  input logic              irq_out,
  input logic              mask,
  input logic              irq_flag
);
  logic hw, hr;
  assign hw = host_sel & host_we;
  assign hr = host_sel & ~host_we;

  AST_START_SETS_RUN: assert property (@(posedge clk) disable iff (rst)
    (hw && host_addr == PC_HI) |=> run); // R3

  AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
    (core_stop && !(hw && (host_addr == PC_HI || host_addr == ADDR_W'('h030)))) |=> !run); // R4

  AST_IRQ_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    core_irq |=> irq_flag); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    $past(mask) |-> !irq_out); // R6

  AST_CBASE_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (hr && host_addr == ADDR_W'('h03E)) |=> host_rdata[3:0] == 4'h0); // R7

  AST_VERSION_READ: assert property (@(posedge clk) disable iff (rst)
    (hr && host_addr == ADDR_W'('h03B)) |=> host_rdata == VERSION); // R8

  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (hr && host_addr == ADDR_W'('h032)) |=> host_rdata == 8'h00); // R11
endmodule

bind gfx_host_regs gfxw_checker #(.ADDR_W(ADDR_W), .VERSION(VERSION), .PC_HI(ADDR_W'(2 * NUM_GPR - 1))) u_chk (
  .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
  .host_addr(host_addr), .host_rdata(host_rdata), .core_irq(core_irq),
  .core_stop(core_stop), .run(run), .irq_out(irq_out), .mask(cfg_mask),
  .irq_flag(sfr[15])
);

// File: tb/tb_gfx_host_regs.sv
`timescale 1ns/1ps
module tb_gfx_host_regs;
  localparam int AW = 10;
  logic clk = 1'b0, rst = 1'b1;
  logic host_sel = 0, host_we = 0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic core_flags_we = 0, core_irq = 0, core_stop = 0;
  logic [15:0] core_flags = '0, cache_base;
  logic run, irq_out, rom_grant, ram_grant, fast_mult, clk_double, backup_ram_en;
  logic [1:0] depth_code, height_code;
  logic [7:0] prog_bank, rom_bank, ram_bank, screen_base;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic rd_pend = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  gfx_host_regs dut (.*);

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares each returned read byte against the scoreboard
  always @(posedge clk) rd_pend <= host_sel && !host_we && !rst;
  always @(negedge clk) if (rd_pend) begin
    if (exp_q.size() == 0) chk(16'hDEAD, 16'h0, "scoreboard underrun");
    else chk({8'h0, host_rdata}, {8'h0, exp_q.pop_front()}, tag_q.pop_front());
  end

  task automatic wr(input int a, input logic [7:0] d);
    host_sel = 1; host_we = 1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_we = 0;
  endtask

  task automatic rd(input int a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    host_sel = 1; host_we = 0; host_addr = AW'(a);
    @(negedge clk);
    host_sel = 0;
  endtask

  task automatic pulse_irq();  core_irq = 1;  @(negedge clk); core_irq = 0;  endtask
  task automatic pulse_stop(); core_stop = 1; @(negedge clk); core_stop = 0; endtask
  task automatic load_flags(input logic [15:0] v);
    core_flags_we = 1; core_flags = v; @(negedge clk); core_flags_we = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    chk(run, 0, "R2 reset run"); chk(irq_out, 0, "R6 reset irq_out");
    chk(depth_code, 0, "R9 reset depth");
    rd('h030, 8'h00, "R2 reset sfr lo"); rd('h031, 8'h00, "R2 reset sfr hi");
    rd('h03B, 8'h04, "R8 version");

    // R1 general registers
    wr('h004, 8'h34); wr('h005, 8'h12);
    rd('h004, 8'h34, "R1 r2 low"); rd('h005, 8'h12, "R1 r2 high");
    wr('h004, 8'hAB);
    rd('h005, 8'h12, "R1 high kept"); rd('h004, 8'hAB, "R1 low rewritten");
    wr('h000, 8'h11); wr('h01C, 8'h55); rd('h01C, 8'h55, "R1 r14 low");
    chk(run, 0, "R3 no start yet");
    wr('h01E, 8'h00); chk(run, 0, "R3 pc low no start");

    // R3 / R4 start and stop
    wr('h01F, 8'h80); chk(run, 1, "R3 start");
    rd('h030, 8'h20, "R3 sfr bit5");
    pulse_stop(); chk(run, 0, "R4 stop");
    core_stop = 1; wr('h01F, 8'h80); core_stop = 0;
    chk(run, 1, "R4 start beats stop");
    pulse_stop(); chk(run, 0, "R4 stop again");

    // R5 / R6 interrupt
    pulse_irq(); chk(irq_out, 0, "R6 lag");
    @(negedge clk); chk(irq_out, 1, "R6 irq_out");
    rd('h031, 8'h80, "R5 irq read"); rd('h031, 8'h00, "R5 irq cleared");
    chk(irq_out, 0, "R6 irq_out drops");
    core_irq = 1; rd('h031, 8'h00, "R5 coincident read"); core_irq = 0;
    rd('h031, 8'h80, "R5 set wins"); rd('h031, 8'h00, "R5 cleared after");

    // R10 / R6 configuration and mask
    wr('h037, 8'hFF); rd('h037, 8'hA0, "R10 cfg keep");
    chk(fast_mult, 1, "R10 fast_mult");
    pulse_irq(); repeat (2) @(negedge clk); chk(irq_out, 0, "R6 masked");
    wr('h037, 8'h00); @(negedge clk); chk(irq_out, 1, "R6 unmasked");
    rd('h031, 8'h80, "R5 flag held under mask");
    @(negedge clk); chk(irq_out, 0, "R6 after clear");

    // R7 cache base
    wr('h03E, 8'hFF); wr('h03F, 8'hC3);
    rd('h03E, 8'hF0, "R7 low nibble"); rd('h03F, 8'hC3, "R7 high");
    chk(cache_base, 16'hC3F0, "R7 port");

    // R8 version read-only
    wr('h03B, 8'h99); rd('h03B, 8'h04, "R8 write ignored");

    // R9 screen mode
    wr('h03A, 8'hFF);
    chk(depth_code, 3, "R9 depth 11"); chk(height_code, 3, "R9 height 11");
    chk(rom_grant, 1, "R9 rom"); chk(ram_grant, 1, "R9 ram");
    wr('h03A, 8'h21);
    chk(depth_code, 1, "R9 depth 01"); chk(height_code, 2, "R9 height 10");
    chk(rom_grant, 0, "R9 rom off");
    wr('h03A, 8'h14);
    chk(depth_code, 0, "R9 depth 00"); chk(height_code, 1, "R9 height 01");
    chk(rom_grant, 1, "R9 rom on"); chk(ram_grant, 0, "R9 ram off");
    rd('h03A, 8'h14, "R9 readback");
    wr('h039, 8'hFF); chk(clk_double, 1, "R10 clk");
    rd('h039, 8'h01, "R10 clk keep");
    wr('h033, 8'hFF); rd('h033, 8'h01, "R10 bram keep");
    chk(backup_ram_en, 1, "R10 bram port");

    // R13 banks
    wr('h034, 8'h5A); wr('h036, 8'hC1); wr('h03C, 8'h3E); wr('h038, 8'h77);
    rd('h034, 8'h5A, "R13 pbank"); chk(prog_bank, 8'h5A, "R13 prog_bank");
    chk(rom_bank, 8'hC1, "R13 rom_bank"); chk(ram_bank, 8'h3E, "R13 ram_bank");
    chk(screen_base, 8'h77, "R13 screen_base");

    // R11 gaps
    wr('h032, 8'hFF); wr('h020, 8'h77); wr('h100, 8'h55); wr('h035, 8'h66);
    rd('h032, 8'h00, "R11 gap 032"); rd('h020, 8'h00, "R11 gap 020");
    rd('h100, 8'h00, "R11 gap 100"); rd('h035, 8'h00, "R11 gap 035");
    rd('h000, 8'h11, "R11 r0 untouched"); chk(rom_bank, 8'hC1, "R11 rom_bank kept");

    // R2 / R12 status writes
    wr('h030, 8'hFF); chk(run, 1, "R2 host sets G");
    rd('h030, 8'h7E, "R2 lo mask");
    wr('h031, 8'hFF); rd('h031, 8'h1F, "R2 hi mask no irq");
    load_flags(16'h0000);
    rd('h030, 8'h20, "R12 clear keeps G"); rd('h031, 8'h00, "R12 clear hi");
    chk(run, 1, "R12 run kept");
    load_flags(16'hFFFF);
    rd('h030, 8'h7E, "R12 set lo"); rd('h031, 8'h1F, "R12 irq untouched");
    pulse_stop(); rd('h030, 8'h5E, "R4 stop leaves flags");

    @(negedge clk); @(negedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule